// File: doc/BRIEF.md
# On-Screen Display Pixel Layer Compositor

This block forms the final colour of one on-screen-display dot. For every dot the caller presents a pixel bundle on a valid/ready input: the dot's own font bit, its eight surrounding font bits, the attributes of the character cell and of the text line, the position of the dot on a shaded frame's edges, and the shared highlight, shadow and screen colours. The block stacks five layers. The screen background is at the bottom. Above it come the line background, then the character background, then the outline (trimming) ring around glyphs, and the glyph dot is on top. It emits a 4-bit colour code and a display-period flag through a single registered valid/ready output stage.

A small configuration register is written with a one-cycle strobe. It holds the character enable, which covers characters and both background layers, the screen background enable, and the polarity of each output. After reset all of its bits are 0. The display is then dark and both outputs use positive logic. The upstream pixel pipeline feeds the input. The output drives the colour and blanking pins. The output holds its value while stalled, so the upstream pipeline can be frozen when the consumer pauses.

Top module: `osd_pixel_compositor`

## Requirements
- R1: After reset, out_valid, out_color and out_period are 0 and every configuration bit is 0. A pixel accepted before any configuration write therefore leaves as colour 0 with out_period 0.
- R2: in_ready is high when the output stage is empty or out_ready is high. A pixel is accepted when in_valid and in_ready are both high, and it appears on the output one cycle later. While out_valid is high and out_ready is low, out_valid, out_color and out_period hold steady. A configuration write changes only pixels accepted after the strobe cycle.
- R3: The layers are ordered from top to bottom as glyph dot (ch_fg_col), trimming (ln_trim_col), character background, line background, and screen background (scr_col). If no layer is opaque, the colour is 0.
- R4: A dot is a trimming dot when px_dot is 0 and at least one bit of px_nbr is 1. Trimming is active only when ln_trim_ctl is 2'b11. The codes 00, 01 and 10 all turn it off.
- R5: ln_trim_sel decides which character-background modes allow trimming. 00 allows none. 01 allows only mode 00. 10 allows modes 00 and 01. 11 allows all modes.
- R6: Background mode encoding: 00 none, 01 solid, 10 concave shaded, 11 convex shaded. This applies to both ch_bg_mode and ln_bg_mode. For a solid background, and inside a shaded frame, the character background shows ch_bg_col, but colour code 0 is transparent. The line background shows ln_bg_col for any colour code.
- R7: On a shaded frame, a dot flagged top/left takes shadow_col when the frame is concave and hilite_col when it is convex. A dot flagged bottom/right takes the other colour. If both flags are set, top/left wins. Edge dots are opaque whatever the background colour code.
- R8: When ln_show is 0, the glyph dot, trimming and character background are suppressed, and the line background is unaffected.
- R9: out_period is 1 when the glyph, trimming, character background or line background is opaque at the dot. The screen background alone does not set it.
- R10: A configuration polarity bit of 1 inverts the matching output. cfg_inv_color inverts all four colour bits and cfg_inv_period inverts out_period.
- R11: When the screen background is disabled, the bottom layer is colour 0. When the character enable is 0, only the screen background can appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads the four configuration bits below |
| cfg_chr_en | input | 1 | Enable for characters and both background layers |
| cfg_scr_en | input | 1 | Screen background enable |
| cfg_inv_color | input | 1 | Invert colour output |
| cfg_inv_period | input | 1 | Invert display-period output |
| in_valid | input | 1 | Pixel bundle valid |
| in_ready | output | 1 | Pixel bundle accepted when high with in_valid |
| px_dot | input | 1 | Font bit of this dot |
| px_nbr | input | NBR | Font bits of the eight surrounding dots |
| ch_fg_col | input | CW | Glyph colour |
| ch_bg_col | input | CW | Character background colour, 0 transparent |
| ch_bg_mode | input | 2 | Character background mode |
| ch_frm_tl | input | 1 | Dot on the top/left edge of the character frame |
| ch_frm_br | input | 1 | Dot on the bottom/right edge of the character frame |
| ln_show | input | 1 | Per-line character output enable |
| ln_trim_ctl | input | 2 | Trimming control |
| ln_trim_sel | input | 2 | Trimming permission by background mode |
| ln_trim_col | input | CW | Trimming colour |
| ln_bg_col | input | CW | Line background colour |
| ln_bg_mode | input | 2 | Line background mode |
| ln_frm_tl | input | 1 | Dot on the top/left edge of the line frame |
| ln_frm_br | input | 1 | Dot on the bottom/right edge of the line frame |
| hilite_col | input | CW | Frame highlight colour |
| shadow_col | input | CW | Frame shadow colour |
| scr_col | input | CW | Screen background colour |
| out_valid | output | 1 | Output dot valid |
| out_ready | input | 1 | Consumer accepts the output dot |
| out_color | output | CW | Colour code after polarity |
| out_period | output | 1 | Display-period flag after polarity |

## Verification
A wrong configuration bit shows up on the very next accepted pixel. A lost enable shows as a dark dot or as screen colour where a layer was expected, and a wrong polarity bit flips every output bit. A fault in the output register's hold logic appears in the first stalled cycle as a changed or dropped value. A double acceptance shows as a pixel that differs from what the reference expects one cycle later. Priority and trimming-permission faults affect only particular attribute combinations, so the directed dots sweep each layer transition and each permission code, and a long randomised stream with back-pressure covers the remaining combinations.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int COLOR_W = 4;
  localparam int NBR_W   = 8;

  typedef enum logic [1:0] {
    BG_NONE    = 2'b00,
    BG_SOLID   = 2'b01,
    BG_CONCAVE = 2'b10,
    BG_CONVEX  = 2'b11
  } bg_mode_e;

  typedef enum logic [1:0] {
    TS_NEVER = 2'b00,
    TS_BARE  = 2'b01,
    TS_FLAT  = 2'b10,
    TS_ANY   = 2'b11
  } trim_sel_e;

  localparam logic [1:0] TRIM_EIGHT = 2'b11;

  localparam int LAYER_CHR = 0;
  localparam int LAYER_LN  = 1;
  localparam int N_BG_LAYERS = 2;
endpackage

// File: rtl/osd_trim_unit.sv
module osd_trim_unit #(
  parameter int NBR = osd_pkg::NBR_W
) (
  input  logic           own_dot,
  input  logic [NBR-1:0] nbr,
  input  logic [1:0]     ctl,
  input  logic [1:0]     sel,
  input  logic [1:0]     cbg_mode,
  output logic           hit
);
  import osd_pkg::*;

  logic ring;
  logic permit;

  always_comb begin
    ring = !own_dot && (|nbr);
    case (trim_sel_e'(sel))
      TS_NEVER: permit = 1'b0;
      TS_BARE:  permit = (bg_mode_e'(cbg_mode) == BG_NONE);
      TS_FLAT:  permit = (bg_mode_e'(cbg_mode) == BG_NONE) ||
                         (bg_mode_e'(cbg_mode) == BG_SOLID);
      default:  permit = 1'b1;
    endcase
    hit = (ctl == TRIM_EIGHT) && ring && permit;
  end
endmodule

// File: rtl/osd_shade_pick.sv
module osd_shade_pick #(
  parameter int CW         = osd_pkg::COLOR_W,
  parameter bit ZERO_CLEAR = 1'b0
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] base_col,
  input  logic [CW-1:0] hi_col,
  input  logic [CW-1:0] sh_col,
  input  logic          frm_tl,
  input  logic          frm_br,
  output logic          opaque,
  output logic [CW-1:0] color
);
  import osd_pkg::*;

  logic base_vis;
  logic convex;

  always_comb begin
    base_vis = !(ZERO_CLEAR && (base_col == '0));
    convex   = (bg_mode_e'(mode) == BG_CONVEX);
    opaque   = 1'b0;
    color    = base_col;
    case (bg_mode_e'(mode))
      BG_NONE:  opaque = 1'b0;
      BG_SOLID: opaque = base_vis;
      default: begin
        if (frm_tl) begin
          opaque = 1'b1;
          color  = convex ? hi_col : sh_col;
        end else if (frm_br) begin
          opaque = 1'b1;
          color  = convex ? sh_col : hi_col;
        end else begin
          opaque = base_vis;
        end
      end
    endcase
  end
endmodule

// File: rtl/osd_out_stage.sv
module osd_out_stage #(
  parameter int CW = osd_pkg::COLOR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] d_color,
  input  logic          d_period,
  input  logic          inv_color,
  input  logic          inv_period,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_color,
  output logic          out_period
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_color  <= '0;
      out_period <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        out_color  <= d_color ^ {CW{inv_color}};
        out_period <= d_period ^ inv_period;
      end
    end
  end
endmodule

// File: rtl/osd_pixel_compositor.sv
module osd_pixel_compositor #(
  parameter int CW  = osd_pkg::COLOR_W,
  parameter int NBR = osd_pkg::NBR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_chr_en,
  input  logic           cfg_scr_en,
  input  logic           cfg_inv_color,
  input  logic           cfg_inv_period,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           px_dot,
  input  logic [NBR-1:0] px_nbr,
  input  logic [CW-1:0]  ch_fg_col,
  input  logic [CW-1:0]  ch_bg_col,
  input  logic [1:0]     ch_bg_mode,
  input  logic           ch_frm_tl,
  input  logic           ch_frm_br,
  input  logic           ln_show,
  input  logic [1:0]     ln_trim_ctl,
  input  logic [1:0]     ln_trim_sel,
  input  logic [CW-1:0]  ln_trim_col,
  input  logic [CW-1:0]  ln_bg_col,
  input  logic [1:0]     ln_bg_mode,
  input  logic           ln_frm_tl,
  input  logic           ln_frm_br,
  input  logic [CW-1:0]  hilite_col,
  input  logic [CW-1:0]  shadow_col,
  input  logic [CW-1:0]  scr_col,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CW-1:0]  out_color,
  output logic           out_period
);
  import osd_pkg::*;

  localparam int NL = N_BG_LAYERS;

  // configuration register, all clear after reset (display off, positive logic)
  logic chr_en_q, scr_en_q, inv_col_q, inv_per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_en_q  <= 1'b0;
      scr_en_q  <= 1'b0;
      inv_col_q <= 1'b0;
      inv_per_q <= 1'b0;
    end else if (cfg_we) begin
      chr_en_q  <= cfg_chr_en;
      scr_en_q  <= cfg_scr_en;
      inv_col_q <= cfg_inv_color;
      inv_per_q <= cfg_inv_period;
    end
  end

  // background layers share one shading rule; the character layer treats code 0 as clear
  logic [1:0]    lay_mode [NL];
  logic [CW-1:0] lay_base [NL];
  logic          lay_tl   [NL];
  logic          lay_br   [NL];
  logic          lay_op   [NL];
  logic [CW-1:0] lay_col  [NL];

  assign lay_mode[LAYER_CHR] = ch_bg_mode;
  assign lay_base[LAYER_CHR] = ch_bg_col;
  assign lay_tl[LAYER_CHR]   = ch_frm_tl;
  assign lay_br[LAYER_CHR]   = ch_frm_br;
  assign lay_mode[LAYER_LN]  = ln_bg_mode;
  assign lay_base[LAYER_LN]  = ln_bg_col;
  assign lay_tl[LAYER_LN]    = ln_frm_tl;
  assign lay_br[LAYER_LN]    = ln_frm_br;

  for (genvar g = 0; g < NL; g++) begin : g_bg
    osd_shade_pick #(
      .CW        (CW),
      .ZERO_CLEAR(g == LAYER_CHR)
    ) i_shade (
      .mode    (lay_mode[g]),
      .base_col(lay_base[g]),
      .hi_col  (hilite_col),
      .sh_col  (shadow_col),
      .frm_tl  (lay_tl[g]),
      .frm_br  (lay_br[g]),
      .opaque  (lay_op[g]),
      .color   (lay_col[g])
    );
  end

  logic trim_hit;

  osd_trim_unit #(.NBR(NBR)) i_trim (
    .own_dot (px_dot),
    .nbr     (px_nbr),
    .ctl     (ln_trim_ctl),
    .sel     (ln_trim_sel),
    .cbg_mode(ch_bg_mode),
    .hit     (trim_hit)
  );

  // layer visibility after global and per-line gating
  logic          show;
  logic          v_dot, v_trim, v_cbg, v_lbg;
  logic [CW-1:0] mix_col;
  logic          mix_per;

  always_comb begin
    show   = chr_en_q && ln_show;
    v_dot  = show && px_dot;
    v_trim = show && trim_hit;
    v_cbg  = show && lay_op[LAYER_CHR];
    v_lbg  = chr_en_q && lay_op[LAYER_LN];
    mix_per = v_dot || v_trim || v_cbg || v_lbg;
    if (v_dot)       mix_col = ch_fg_col;
    else if (v_trim) mix_col = ln_trim_col;
    else if (v_cbg)  mix_col = lay_col[LAYER_CHR];
    else if (v_lbg)  mix_col = lay_col[LAYER_LN];
    else if (scr_en_q) mix_col = scr_col;
    else             mix_col = '0;
  end

  osd_out_stage #(.CW(CW)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_color   (mix_col),
    .d_period  (mix_per),
    .inv_color (inv_col_q),
    .inv_period(inv_per_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_color (out_color),
    .out_period(out_period)
  );
endmodule

// File: rtl/osd_pixel_compositor_chk.sv
module osd_pixel_compositor_chk #(
  parameter int CW = osd_pkg::COLOR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_color,
  input logic          out_period,
  input logic          chr_en_q,
  input logic          scr_en_q,
  input logic          inv_col_q,
  input logic          inv_per_q,
  input logic          px_dot,
  input logic          ln_show
);
  // stalled output keeps its value (R2)
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_color) && $stable(out_period));

  // an accepted pixel is presented on the next cycle (R2)
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // no acceptance while the output is stalled (R2)
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // with every layer disabled the dot is blank apart from polarity (R1, R11)
  p_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !chr_en_q && !scr_en_q |=>
      out_color == {CW{$past(inv_col_q)}} && out_period == $past(inv_per_q));

  // a shown glyph dot always marks the display period (R9)
  p_dot_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && chr_en_q && ln_show && px_dot |=>
      out_period != $past(inv_per_q));
endmodule

bind osd_pixel_compositor osd_pixel_compositor_chk #(.CW(CW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_color (out_color),
  .out_period(out_period),
  .chr_en_q  (chr_en_q),
  .scr_en_q  (scr_en_q),
  .inv_col_q (inv_col_q),
  .inv_per_q (inv_per_q),
  .px_dot    (px_dot),
  .ln_show   (ln_show)
);

// File: tb/test_osd_pixel_compositor.sv
module test_osd_pixel_compositor;
  localparam int CW  = 4;
  localparam int NBR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_chr_en = 0, cfg_scr_en = 0, cfg_inv_color = 0, cfg_inv_period = 0;
  logic in_valid = 0;
  logic in_ready;
  logic px_dot = 0;
  logic [NBR-1:0] px_nbr = '0;
  logic [CW-1:0] ch_fg_col = '0, ch_bg_col = '0, ln_trim_col = '0, ln_bg_col = '0;
  logic [CW-1:0] hilite_col = '0, shadow_col = '0, scr_col = '0;
  logic [1:0] ch_bg_mode = '0, ln_trim_ctl = '0, ln_trim_sel = '0, ln_bg_mode = '0;
  logic ch_frm_tl = 0, ch_frm_br = 0, ln_frm_tl = 0, ln_frm_br = 0, ln_show = 0;
  logic out_valid, out_ready = 1'b1, out_period;
  logic [CW-1:0] out_color;

  always #5 clk = ~clk;

  osd_pixel_compositor #(.CW(CW), .NBR(NBR)) i_osd_pixel_compositor (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit m_chr = 0, m_scr = 0, m_icol = 0, m_iper = 0;
  bit m_valid = 0;
  int m_col = 0;
  bit m_per = 0;
  string m_tag = "R1";

  function automatic int shade(int mode, int base, bit tl, bit br, bit clear0);
    if (mode == 0) return -1;
    if (mode >= 2 && tl) return (mode == 3) ? int'(hilite_col) : int'(shadow_col);
    if (mode >= 2 && br) return (mode == 3) ? int'(shadow_col) : int'(hilite_col);
    if (clear0 && base == 0) return -1;
    return base;
  endfunction

  // paints layers bottom-up; returns {period, colour} before polarity
  function automatic int ref_pix();
    int col = m_scr ? int'(scr_col) : 0;
    bit per = 0;
    int c;
    bit ok;
    if (m_chr) begin
      c = shade(ln_bg_mode, ln_bg_col, ln_frm_tl, ln_frm_br, 0);
      if (c >= 0) begin col = c; per = 1; end
      if (ln_show) begin
        c = shade(ch_bg_mode, ch_bg_col, ch_frm_tl, ch_frm_br, 1);
        if (c >= 0) begin col = c; per = 1; end
        ok = (ln_trim_sel == 3) || (ln_trim_sel == 2 && ch_bg_mode <= 1) ||
             (ln_trim_sel == 1 && ch_bg_mode == 0);
        if (!px_dot && px_nbr != 0 && ln_trim_ctl == 3 && ok) begin
          col = ln_trim_col; per = 1;
        end
        if (px_dot) begin col = ch_fg_col; per = 1; end
      end
    end
    return (int'(per) << 4) | col;
  endfunction

  task automatic step(input string tag);
    bit exp_rdy, nv, np;
    int nc, r;
    string nt;
    #1;
    exp_rdy = !m_valid || out_ready;
    n_cmp++;
    if (in_ready !== exp_rdy) begin
      n_bad++;
      $display("FAIL R2 in_ready: actual %0b expected %0b", in_ready, exp_rdy);
    end
    nv = m_valid; nc = m_col; np = m_per; nt = m_tag;
    if (m_valid && out_ready) nv = 0;
    if (in_valid && exp_rdy) begin
      r  = ref_pix();
      nv = 1;
      nc = (r & 15) ^ (m_icol ? 15 : 0);
      np = r[4] ^ m_iper;
      nt = tag;
    end
    @(posedge clk);
    m_valid = nv; m_col = nc; m_per = np; m_tag = nt;
    if (cfg_we) begin
      m_chr = cfg_chr_en; m_scr = cfg_scr_en; m_icol = cfg_inv_color; m_iper = cfg_inv_period;
    end
    @(negedge clk);
    n_cmp++;
    if (out_valid !== m_valid ||
        (m_valid && (int'(out_color) != m_col || out_period !== m_per))) begin
      n_bad++;
      $display("FAIL %s: valid %0b color %0d period %0b, expected valid %0b color %0d period %0b",
               m_tag, out_valid, out_color, out_period, m_valid, m_col, m_per);
    end
  endtask

  task automatic write_cfg(input bit chr, input bit scr, input bit ic, input bit ip);
    cfg_we = 1; cfg_chr_en = chr; cfg_scr_en = scr; cfg_inv_color = ic; cfg_inv_period = ip;
    in_valid = 0;
    step("R2");
    cfg_we = 0;
  endtask

  task automatic base_attrs();
    in_valid = 1; out_ready = 1; cfg_we = 0;
    px_dot = 0; px_nbr = '0;
    ch_fg_col = 9; ch_bg_col = 7; ch_bg_mode = 2'b01; ch_frm_tl = 0; ch_frm_br = 0;
    ln_show = 1; ln_trim_ctl = 2'b11; ln_trim_sel = 2'b11; ln_trim_col = 10;
    ln_bg_col = 6; ln_bg_mode = 2'b01; ln_frm_tl = 0; ln_frm_br = 0;
    hilite_col = 12; shadow_col = 13; scr_col = 5;
  endtask

  task automatic rnd_attrs();
    px_dot = 1'($urandom); px_nbr = NBR'($urandom % 3 == 0 ? 0 : $urandom);
    ch_fg_col = 4'($urandom); ch_bg_col = 4'($urandom % 4 == 0 ? 0 : $urandom);
    ch_bg_mode = 2'($urandom); ch_frm_tl = 1'($urandom); ch_frm_br = 1'($urandom);
    ln_show = ($urandom % 5) != 0; ln_trim_ctl = 2'($urandom); ln_trim_sel = 2'($urandom);
    ln_trim_col = 4'($urandom); ln_bg_col = 4'($urandom); ln_bg_mode = 2'($urandom);
    ln_frm_tl = 1'($urandom); ln_frm_br = 1'($urandom);
    hilite_col = 4'($urandom); shadow_col = 4'($urandom); scr_col = 4'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at the ports
    n_cmp++;
    if (out_valid !== 0 || out_color !== 0 || out_period !== 0) begin
      n_bad++;
      $display("FAIL R1: valid %0b color %0d period %0b expected 0 0 0", out_valid, out_color, out_period);
    end
    // R1: unconfigured block emits a dark dot even for a glyph dot
    base_attrs(); px_dot = 1; step("R1");
    in_valid = 0; step("R1");

    write_cfg(1, 1, 0, 0);
    base_attrs();
    px_dot = 1; px_nbr = '1;           step("R3 glyph over all");
    px_dot = 0; px_nbr = 8'h01;        step("R3 trim over char bg");
    ln_trim_ctl = 2'b01;               step("R4 reserved 01 off");
    ln_trim_ctl = 2'b10;               step("R4 reserved 10 off");
    ln_trim_ctl = 2'b11; px_nbr = 8'h80; step("R4 trim from far neighbour");
    ln_trim_sel = 2'b01;               step("R5 bare only, solid bg blocks");
    ch_bg_mode = 2'b00;                step("R5 bare only, no bg trims");
    ln_trim_sel = 2'b10; ch_bg_mode = 2'b01; step("R5 flat allows solid");
    ch_bg_mode = 2'b11;                step("R5 flat blocks shaded");
    ln_trim_sel = 2'b00; ch_bg_mode = 2'b00; step("R5 never");
    ln_trim_ctl = 2'b00; ch_bg_mode = 2'b01; ch_bg_col = 0; step("R6 clear char bg");
    ch_bg_col = 7; ch_bg_mode = 2'b10; step("R6 shaded interior");
    ch_frm_tl = 1;                     step("R7 concave top-left shadow");
    ch_bg_mode = 2'b11;                step("R7 convex top-left highlight");
    ch_frm_tl = 0; ch_frm_br = 1;      step("R7 convex bottom-right shadow");
    ch_bg_mode = 2'b10; ch_bg_col = 0; step("R7 concave bottom-right highlight, clear base");
    ch_frm_tl = 1;                     step("R7 both flags, top-left wins");
    ch_frm_tl = 0; ch_frm_br = 0; ln_bg_mode = 2'b11; ln_frm_br = 1; ch_bg_mode = 0; step("R7 line convex edge");
    ln_frm_br = 0; ln_bg_mode = 2'b01; ln_bg_col = 0; step("R6 line bg code 0 opaque");
    ln_bg_col = 6; ln_show = 0; px_dot = 1; ch_bg_mode = 2'b01; ch_bg_col = 7; step("R8 line hidden");
    ln_bg_mode = 0;                    step("R9 only screen, period low");
    ln_show = 1;                       step("R9 glyph sets period");
    write_cfg(1, 0, 0, 0);
    px_dot = 0; ch_bg_mode = 0; ln_trim_ctl = 0; step("R11 screen off");
    write_cfg(0, 1, 0, 0);
    px_dot = 1; ln_bg_mode = 2'b01;    step("R11 chr off, screen only");
    write_cfg(1, 1, 1, 1);
    step("R10 inverted glyph");
    px_dot = 0; ln_bg_mode = 0;        step("R10 inverted screen");
    write_cfg(1, 1, 0, 1);
    step("R10 period only inverted");

    // R2: random stream with back-pressure and occasional configuration writes
    for (int i = 0; i < 600; i++) begin
      rnd_attrs();
      in_valid = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      cfg_we = ($urandom % 25) == 0;
      cfg_chr_en = ($urandom % 5) != 0; cfg_scr_en = 1'($urandom);
      cfg_inv_color = ($urandom % 4) == 0; cfg_inv_period = ($urandom % 4) == 0;
      step("R2 random stream");
    end
    cfg_we = 0; in_valid = 0; out_ready = 1;
    step("R2 drain");
    step("R2 drain");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule